// File: doc/BRIEF.md
# GF(2) Multiply-Modulo Unit for CRC-16

This unit multiplies two 16-bit polynomials over GF(2) and returns the product reduced modulo the CRC-16 generator x^16 + x^12 + x^5 + 1. Each operand bit is the coefficient of one power of x, with bit i holding x^i.

The product is formed without carries, as 31 parallel XOR trees. The reduction does not use bit-serial long division. The upper product bits are multiplied by a reciprocal constant, floor(x^31 / P), to estimate the quotient. That quotient times P is then XORed away from the lower product bits. The reciprocal is computed once, as an elaboration-time constant.

A typical use is a CRC that consumes a message from its last byte to its first. One multiply advances a padding multiplier by x^8. A second multiply scales the current byte by that multiplier, and the scaled byte is XORed into the running CRC. A parameter chooses between a purely combinational path and one output register stage. The valid flag follows the chosen latency.

Top module: `gfm_mulmod`

## Requirements
- R1: For any operand pair, `out_rem` equals (in_a · in_b) mod P, where · is a carryless product and P = 0x11021.
- R2: When either operand is 0x0000, the result is 0x0000.
- R3: When one operand is 0x0001, the result equals the other operand.
- R4: Swapping the two operands does not change the result.
- R5: 0x0100 · 0x0100 (x^16) gives 0x1021. 0x8000 · 0x0002 gives 0x1021 as well.
- R6: With the output register enabled (the default), `out_vld` and the matching `out_rem` appear one clock after `in_vld`. Back-to-back inputs give back-to-back results.
- R7: With the output register enabled, `out_vld` is low in every cycle after a cycle without `in_vld`, and `out_rem` keeps its last value.
- R8: During and right after reset, `out_vld` is 0 and `out_rem` is 0x0000.
- R9: A padding multiplier chain (repeated multiplies by 0x0100) and per-byte scaling, run through the unit, produce CRC-16 with zero initial value for a message fed last byte first. "123456789" gives 0x31C3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used when the output register is enabled |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| in_a | input | 16 | First polynomial operand, bit i = coefficient of x^i |
| in_b | input | 16 | Second polynomial operand |
| out_vld | output | 1 | Result valid |
| out_rem | output | 16 | (in_a · in_b) mod P |

## Verification
A wrong AND pair or a broken XOR tree node flips one product bit. That fault appears in `out_rem` one cycle after any operand pair that exercises it. Random pairs expose it within a few vectors.

A wrong reciprocal or quotient bit gives a remainder that is off by a multiple of P. Only operands whose product reaches x^16 or above show this error. The x^16 corner cases and the byte-reversed CRC chain catch it directly, because an error early in the chain carries into every later multiplier.

A latency or hold fault is seen at `out_vld` and `out_rem` within the cycle after the input.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    localparam int unsigned GF_W = 16;
    localparam int unsigned GF_PROD_W = 2 * GF_W - 1;

    typedef logic [GF_W-1:0] gf_elem_t;

    // Default generator, implicit leading x^16 dropped
    localparam gf_elem_t GF_POLY_LO = 16'h1021;

    typedef struct packed {
        logic     vld;
        gf_elem_t rem;
    } gf_out_t;

    // floor(x^(2W-1) / P) by shift-and-conditional-XOR division
    function automatic gf_elem_t gf_recip(input gf_elem_t plo);
        logic [2*GF_W-1:0] num;
        logic [2*GF_W-1:0] pfull;
        gf_elem_t          quo;
        num   = '0;
        num[2*GF_W-1] = 1'b1;
        pfull = '0;
        pfull[GF_W-1:0] = plo;
        pfull[GF_W] = 1'b1;
        quo   = '0;
        for (int i = 2 * GF_W - 1; i >= int'(GF_W); i--) begin
            if (num[i]) begin
                quo[i-GF_W] = 1'b1;
                num = num ^ (pfull << (i - GF_W));
            end
        end
        return quo;
    endfunction

endpackage

// File: rtl/gfm_xor_tree.sv
module gfm_xor_tree #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] x,
    output logic         y
);
    localparam int unsigned LG = (N > 1) ? $clog2(N) : 0;
    localparam int unsigned NP = 1 << LG;

    genvar l, i;
    generate
        for (l = 0; l <= LG; l++) begin : lv
            logic [(NP >> l)-1:0] v;
            if (l == 0) begin : g_leaf
                if (NP == N) begin : g_full
                    assign v = x;
                end else begin : g_pad
                    assign v = {{(NP - N){1'b0}}, x};
                end
            end else begin : g_node
                for (i = 0; i < (NP >> l); i++) begin : g_x
                    assign v[i] = lv[l-1].v[2*i] ^ lv[l-1].v[2*i+1];
                end
            end
        end
    endgenerate

    assign y = lv[LG].v[0];

endmodule

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
    parameter int unsigned AW     = 16,
    parameter int unsigned BW     = 16,
    parameter int unsigned OUT_LO = 0,
    parameter int unsigned OUT_HI = AW + BW - 2
) (
    input  logic [AW-1:0]          a,
    input  logic [BW-1:0]          b,
    output logic [OUT_HI:OUT_LO]   p
);
    genvar k, j;
    generate
        for (k = OUT_LO; k <= OUT_HI; k++) begin : g_bit
            logic [BW-1:0] terms;
            for (j = 0; j < BW; j++) begin : g_term
                if ((k >= j) && (k - j < AW)) begin : g_and
                    assign terms[j] = a[k-j] & b[j];
                end else begin : g_zero
                    assign terms[j] = 1'b0;
                end
            end
            gfm_xor_tree #(.N(BW)) u_tree (
                .x (terms),
                .y (p[k])
            );
        end
    endgenerate

endmodule

// File: rtl/gfm_reduce.sv
module gfm_reduce
    import gfm_pkg::*;
#(
    parameter gf_elem_t POLY_LO = GF_POLY_LO
) (
    input  logic [GF_PROD_W-1:0] prod,
    output gf_elem_t             rem
);
    localparam gf_elem_t    MU   = gf_recip(POLY_LO);
    localparam int unsigned HI_W = GF_PROD_W - GF_W;

    logic [HI_W-1:0]      prod_hi;
    logic [2*GF_W-3:GF_W-1] q_est;
    gf_elem_t             qp_lo;

    assign prod_hi = prod[GF_PROD_W-1:GF_W];

    // quotient = (hi * MU) >> (W-1)
    gfm_clmul #(
        .AW(HI_W), .BW(GF_W), .OUT_LO(GF_W - 1), .OUT_HI(2 * GF_W - 3)
    ) u_quot (
        .a (prod_hi),
        .b (MU),
        .p (q_est)
    );

    // low W bits of quotient * P (the x^W term of P lands above them)
    gfm_clmul #(
        .AW(HI_W), .BW(GF_W), .OUT_LO(0), .OUT_HI(GF_W - 1)
    ) u_back (
        .a (q_est),
        .b (POLY_LO),
        .p (qp_lo)
    );

    assign rem = prod[GF_W-1:0] ^ qp_lo;

endmodule

// File: rtl/gfm_mulmod.sv
module gfm_mulmod
    import gfm_pkg::*;
#(
    parameter gf_elem_t    POLY_LO = GF_POLY_LO,
    parameter int unsigned OUT_REG = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_vld,
    input  gf_elem_t in_a,
    input  gf_elem_t in_b,
    output logic     out_vld,
    output gf_elem_t out_rem
);
    logic [GF_PROD_W-1:0] prod;
    gf_out_t              res_d;
    gf_out_t              res_q;

    gfm_clmul #(.AW(GF_W), .BW(GF_W)) u_mul (
        .a (in_a),
        .b (in_b),
        .p (prod)
    );

    gfm_reduce #(.POLY_LO(POLY_LO)) u_red (
        .prod (prod),
        .rem  (res_d.rem)
    );

    assign res_d.vld = in_vld;

    generate
        if (OUT_REG != 0) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                end else begin
                    res_q.vld <= res_d.vld;
                    if (res_d.vld) begin
                        res_q.rem <= res_d.rem;
                    end
                end
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign out_vld = res_q.vld;
    assign out_rem = res_q.rem;

endmodule

// File: rtl/gfm_mulmod_chk.sv
module gfm_mulmod_chk
    import gfm_pkg::*;
#(
    parameter gf_elem_t    POLY_LO = GF_POLY_LO,
    parameter int unsigned LAT     = 1
) (
    input logic     clk,
    input logic     rst,
    input logic     in_vld,
    input gf_elem_t in_a,
    input gf_elem_t in_b,
    input logic     out_vld,
    input gf_elem_t out_rem
);
    generate
        if (LAT != 0) begin : g_lat1
            AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                in_vld |=> out_vld);                                        // R6
            AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> !out_vld);                                      // R7
            AST_REM_HOLDS: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> $stable(out_rem));                              // R7
            AST_ZERO_ABSORBS: assert property (@(posedge clk) disable iff (rst)
                in_vld && ((in_a == '0) || (in_b == '0)) |=> out_rem == '0); // R2
            AST_UNIT_LEFT: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_a == 16'h0001) |=> out_rem == $past(in_b));   // R3
            AST_UNIT_RIGHT: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_b == 16'h0001) |=> out_rem == $past(in_a));   // R3
            AST_X16_FOLD: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_a == 16'h0100) && (in_b == 16'h0100)
                |=> out_rem == POLY_LO);                                    // R5
        end else begin : g_lat0
            AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                in_vld |-> out_vld);                                        // R6
            AST_ZERO_ABSORBS: assert property (@(posedge clk) disable iff (rst)
                in_vld && ((in_a == '0) || (in_b == '0)) |-> out_rem == '0); // R2
            AST_UNIT_LEFT: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_a == 16'h0001) |-> out_rem == in_b);          // R3
            AST_UNIT_RIGHT: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_b == 16'h0001) |-> out_rem == in_a);          // R3
            AST_X16_FOLD: assert property (@(posedge clk) disable iff (rst)
                in_vld && (in_a == 16'h0100) && (in_b == 16'h0100)
                |-> out_rem == POLY_LO);                                    // R5
        end
    endgenerate

endmodule

bind gfm_mulmod gfm_mulmod_chk #(.POLY_LO(POLY_LO), .LAT(OUT_REG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_rem (out_rem)
);

// File: tb/sim_gfm_mulmod.sv
module sim_gfm_mulmod;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic [15:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_vld;
    logic [15:0] out_rem;

    int n_chk  = 0;
    int n_fail = 0;
    sb_item_t sbq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gfm_mulmod u0 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_a    (in_a),
        .in_b    (in_b),
        .out_vld (out_vld),
        .out_rem (out_rem)
    );

    // Bit-serial reference: shift, fold x^16, add operand
    function automatic logic [15:0] ref_mulmod(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r = '0;
        for (int i = 15; i >= 0; i--) begin
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: called at a negedge, returns at the next negedge
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] exp, input string req);
        sb_item_t it;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
        in_vld = 1'b1;
        in_a   = a;
        in_b   = b;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    // Monitor: results compared one cycle after their inputs (R6)
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (sbq.size() == 0) begin
                check("R6", 16'hDEAD, 16'h0000);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(it.req, out_rem, it.exp);
            end
        end
    end

    task automatic run_crc(input logic [7:0] msg[], input logic [15:0] exp_crc);
        logic [15:0] crc = '0;
        logic [15:0] pdm = 16'h0100;
        logic [15:0] e;
        for (int i = msg.size() - 1; i >= 0; i--) begin
            e = ref_mulmod(16'h0100, pdm);
            apply(16'h0100, pdm, e, "R9");
            pdm = out_rem;
            e = ref_mulmod({8'h00, msg[i]}, pdm);
            apply({8'h00, msg[i]}, pdm, e, "R9");
            crc = crc ^ out_rem;
        end
        check("R9", crc, exp_crc);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [15:0] a, b, held;
        logic [7:0]  m1[] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        logic [7:0]  m2[] = '{8'h43, 8'h76, 8'h66, 8'h9A, 8'h1C, 8'hFC, 8'h04, 8'h83, 8'h21,
                              8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        repeat (3) @(negedge clk);
        check("R8", {15'd0, out_vld}, 16'h0000);
        check("R8", out_rem, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {15'd0, out_vld}, 16'h0000);

        // R2 zero operands
        apply(16'h0000, 16'hBEEF, 16'h0000, "R2");
        apply(16'hFFFF, 16'h0000, 16'h0000, "R2");
        // R3 unit operands
        apply(16'h0001, 16'hA5C3, 16'hA5C3, "R3");
        apply(16'h7E81, 16'h0001, 16'h7E81, "R3");
        // R5 x^16 folding
        apply(16'h0100, 16'h0100, 16'h1021, "R5");
        apply(16'h8000, 16'h0002, 16'h1021, "R5");
        apply(16'hFFFF, 16'hFFFF, ref_mulmod(16'hFFFF, 16'hFFFF), "R1");

        // R4 commutativity and R1 random pairs, back to back (R6)
        for (int n = 0; n < 300; n++) begin
            a = 16'($urandom);
            b = 16'($urandom);
            sbq.push_back('{exp: ref_mulmod(a, b), req: "R1"});
            in_vld = 1'b1; in_a = a; in_b = b;
            @(negedge clk);
            sbq.push_back('{exp: ref_mulmod(a, b), req: "R4"});
            in_a = b; in_b = a;
            @(negedge clk);
            in_vld = 1'b0;
        end

        // R7 hold while idle
        apply(16'h1234, 16'h5678, ref_mulmod(16'h1234, 16'h5678), "R1");
        held = out_rem;
        for (int k = 0; k < 3; k++) begin
            in_a = 16'($urandom); in_b = 16'($urandom);
            @(negedge clk);
            check("R7", {15'd0, out_vld}, 16'h0000);
            check("R7", out_rem, held);
        end

        // R9 byte-reversed CRC chains
        run_crc(m1, 16'h31C3);
        run_crc(m2, 16'h2848);

        @(negedge clk);
        check("R6", 16'(sbq.size()), 16'h0000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule